// File: doc/BRIEF.md
# Five-Operation ALU with Signed Set-Less-Than

This block is a purely combinational arithmetic-logic unit of configurable word width. A three-bit operation code chooses one of five results: sum, difference, a signed "less than" test, bitwise AND, or bitwise OR. The two operands and the code are applied together, and the result and two status flags settle in the same cycle with no clock and no state.

The sum, the difference and the comparison all come from one shared adder-subtractor. Subtraction inverts the second operand bit by bit and feeds a carry of one into the lowest column. The comparison reuses that subtraction and takes the sign of the difference, corrected by the signed-overflow condition. Codes that name no operation give an all-zero result, so every input pattern has a defined output.

Top module: `slt_alu`

## Requirements
- R1: With op_i = 3'b000, z_o equals (x_i + y_i) modulo 2^WIDTH.
- R2: With op_i = 3'b001, z_o equals (x_i - y_i) modulo 2^WIDTH.
- R3: With op_i = 3'b000, c_o is the carry out of the top bit of the sum, and v_o is 1 exactly when two operands of equal sign, read as two's complement, give a sum of the opposite sign.
- R4: With op_i = 3'b001, c_o is 1 exactly when x_i < y_i as unsigned values (a borrow), and v_o is 1 exactly when the two's-complement difference x_i - y_i falls outside the signed WIDTH-bit range.
- R5: With op_i = 3'b011, z_o[0] is 1 when x_i < y_i as two's-complement values and 0 otherwise, and z_o[WIDTH-1:1] is zero.
- R6: With op_i = 3'b100, z_o equals x_i AND y_i, bit by bit.
- R7: With op_i = 3'b110, z_o equals x_i OR y_i, bit by bit.
- R8: With op_i equal to 3'b010, 3'b101 or 3'b111, z_o is all zeros.
- R9: For every op_i other than 3'b000 and 3'b001, c_o and v_o are both 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 3 | Operation code |
| x_i | input | WIDTH | First operand |
| y_i | input | WIDTH | Second operand |
| z_o | output | WIDTH | Result word |
| c_o | output | 1 | Unsigned carry/borrow flag for add and subtract |
| v_o | output | 1 | Signed overflow flag for add and subtract |

## Verification
The bench builds a 4-bit instance and applies every pair of operands under all eight codes. It computes every expected value with integer arithmetic. This sweep reaches the comparisons that cross the signed wrap, such as the most negative value against a positive one, where X - Y overflows. A design that took the raw sign of the difference would give the wrong answer there. The sweep also reaches equal operands, where a less-or-equal mix-up would set the result. It covers the subtract borrow, where returning the raw carry would invert C. Finally, it confirms that the comparison and the unused codes leave the flags and the upper result bits at zero, so any leakage from the shared adder shows up.

// File: rtl/slt_alu_pkg.sv
package slt_alu_pkg;
  typedef enum logic [2:0] {
    OP_ADD = 3'b000,
    OP_SUB = 3'b001,
    OP_SLT = 3'b011,
    OP_AND = 3'b100,
    OP_OR  = 3'b110
  } alu_op_e;
endpackage

// File: rtl/slt_alu_addsub.sv
module slt_alu_addsub #(
  parameter int WIDTH = 32
) (
  input  logic             sub_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o,
  output logic             ovf_o
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] b_cond;
  logic [WIDTH:0]   carry;

  // Each XOR passes b when sub_i is 0 and inverts it when sub_i is 1
  assign b_cond   = b_i ^ {WIDTH{sub_i}};
  assign carry[0] = sub_i;

  for (genvar i = 0; i < WIDTH; i++) begin : g_col
    assign sum_o[i]   = a_i[i] ^ b_cond[i] ^ carry[i];
    assign carry[i+1] = (a_i[i] & b_cond[i]) | (carry[i] & (a_i[i] ^ b_cond[i]));
  end

  assign cout_o = carry[WIDTH];
  // Signed overflow: the carry into the top column differs from the carry out of it
  assign ovf_o  = carry[MSB] ^ carry[WIDTH];

  always_comb begin
    if (!sub_i) begin
      assert_ripple_sum_R1: assert ({cout_o, sum_o} == ({1'b0, a_i} + {1'b0, b_i}))
        else $error("ripple sum disagrees with arithmetic sum");
    end else begin
      assert_ripple_diff_R2: assert (sum_o == a_i - b_i)
        else $error("ripple difference disagrees with arithmetic difference");
      assert_borrow_R4: assert (cout_o == (a_i >= b_i))
        else $error("subtract carry does not match unsigned compare");
    end
  end
endmodule

// File: rtl/slt_alu_bitwise.sv
module slt_alu_bitwise #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] and_o,
  output logic [WIDTH-1:0] or_o
);
  assign and_o = a_i & b_i;
  assign or_o  = a_i | b_i;

  always_comb begin
    assert_and_within_or_R6: assert ((and_o & ~or_o) == '0)
      else $error("AND result has a bit the OR result lacks");
  end
endmodule

// File: rtl/slt_alu_select.sv
module slt_alu_select
  import slt_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [2:0]       op_i,
  input  logic [WIDTH-1:0] arith_i,
  input  logic             cout_i,
  input  logic             ovf_i,
  input  logic [WIDTH-1:0] and_i,
  input  logic [WIDTH-1:0] or_i,
  output logic [WIDTH-1:0] z_o,
  output logic             c_o,
  output logic             v_o
);
  localparam int MSB = WIDTH - 1;

  logic less;
  // The sign of the difference is wrong exactly when the subtraction overflowed
  assign less = arith_i[MSB] ^ ovf_i;

  always_comb begin
    z_o = '0;
    c_o = 1'b0;
    v_o = 1'b0;
    case (op_i)
      OP_ADD: begin
        z_o = arith_i;
        c_o = cout_i;
        v_o = ovf_i;
      end
      OP_SUB: begin
        z_o = arith_i;
        c_o = ~cout_i;
        v_o = ovf_i;
      end
      OP_SLT:  z_o = {{(WIDTH-1){1'b0}}, less};
      OP_AND:  z_o = and_i;
      OP_OR:   z_o = or_i;
      default: z_o = '0;
    endcase
  end
endmodule

// File: rtl/slt_alu.sv
module slt_alu
  import slt_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [2:0]       op_i,
  input  logic [WIDTH-1:0] x_i,
  input  logic [WIDTH-1:0] y_i,
  output logic [WIDTH-1:0] z_o,
  output logic             c_o,
  output logic             v_o
);
  logic             sub_mode;
  logic [WIDTH-1:0] arith;
  logic             arith_cout;
  logic             arith_ovf;
  logic [WIDTH-1:0] and_res;
  logic [WIDTH-1:0] or_res;

  // Comparison borrows the subtract path
  assign sub_mode = (op_i == OP_SUB) || (op_i == OP_SLT);

  slt_alu_addsub #(.WIDTH(WIDTH)) u_addsub (
    .sub_i  (sub_mode),
    .a_i    (x_i),
    .b_i    (y_i),
    .sum_o  (arith),
    .cout_o (arith_cout),
    .ovf_o  (arith_ovf)
  );

  slt_alu_bitwise #(.WIDTH(WIDTH)) u_bitwise (
    .a_i   (x_i),
    .b_i   (y_i),
    .and_o (and_res),
    .or_o  (or_res)
  );

  slt_alu_select #(.WIDTH(WIDTH)) u_select (
    .op_i    (op_i),
    .arith_i (arith),
    .cout_i  (arith_cout),
    .ovf_i   (arith_ovf),
    .and_i   (and_res),
    .or_i    (or_res),
    .z_o     (z_o),
    .c_o     (c_o),
    .v_o     (v_o)
  );

  always_comb begin
    if (op_i == OP_SLT) begin
      assert_slt_upper_zero_R5: assert (z_o[WIDTH-1:1] == '0)
        else $error("compare result has upper bits set");
      assert_slt_sign_R5: assert (z_o[0] == ($signed(x_i) < $signed(y_i)))
        else $error("compare result disagrees with signed less-than");
    end
    if (op_i == 3'b010 || op_i == 3'b101 || op_i == 3'b111) begin
      assert_undef_zero_R8: assert (z_o == '0)
        else $error("unused code gave a nonzero result");
    end
    if (op_i != OP_ADD && op_i != OP_SUB) begin
      assert_flags_quiet_R9: assert (!c_o && !v_o)
        else $error("flags raised outside add and subtract");
    end
  end
endmodule

// File: tb/slt_alu_tb.sv
module slt_alu_tb;
  localparam int W = 4;
  localparam int N = 1 << W;

  logic         clk = 1'b0;
  logic [2:0]   op;
  logic [W-1:0] x, y;
  logic [W-1:0] z;
  logic         c, v;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  slt_alu #(.WIDTH(W)) u_dut (
    .op_i (op),
    .x_i  (x),
    .y_i  (y),
    .z_o  (z),
    .c_o  (c),
    .v_o  (v)
  );

  task automatic check(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s op=%0d x=%0d y=%0d actual=%0d expected=%0d",
               req, what, op, x, y, act, exp);
    end
  endtask

  function automatic int sx(input int u);
    return (u >= N/2) ? u - N : u;
  endfunction

  initial begin
    // Zero inputs on add: result and flags all zero
    op = 3'b000; x = '0; y = '0;
    @(negedge clk);
    check("R1", int'(z), 0, "zero-input result");
    check("R3", int'({c, v}), 0, "zero-input flags");

    for (int o = 0; o < 8; o++) begin
      for (int a = 0; a < N; a++) begin
        for (int b = 0; b < N; b++) begin
          int ez, ec, ev, s;
          string rq;
          @(posedge clk);
          op = 3'(o); x = W'(a); y = W'(b);
          ez = 0; ec = 0; ev = 0;
          case (o)
            0: begin
              ez = (a + b) % N; ec = (a + b >= N) ? 1 : 0;
              s = sx(a) + sx(b); ev = (s > N/2 - 1 || s < -N/2) ? 1 : 0;
              rq = "R1";
            end
            1: begin
              ez = (a - b + N) % N; ec = (a < b) ? 1 : 0;
              s = sx(a) - sx(b); ev = (s > N/2 - 1 || s < -N/2) ? 1 : 0;
              rq = "R2";
            end
            3: begin ez = (sx(a) < sx(b)) ? 1 : 0; rq = "R5"; end
            4: begin ez = a & b; rq = "R6"; end
            6: begin ez = a | b; rq = "R7"; end
            default: begin ez = 0; rq = "R8"; end
          endcase
          @(negedge clk);
          check(rq, int'(z), ez, "result");
          if (o == 0) begin
            check("R3", int'(c), ec, "carry");
            check("R3", int'(v), ev, "overflow");
          end else if (o == 1) begin
            check("R4", int'(c), ec, "borrow");
            check("R4", int'(v), ev, "overflow");
          end else begin
            check("R9", int'({c, v}), 0, "quiet flags");
          end
        end
      end
    end

    // Named corners: most negative against positive, equal operands
    @(posedge clk); op = 3'b011; x = 4'b1000; y = 4'b0111;
    @(negedge clk); check("R5", int'(z), 1, "min < max");
    @(posedge clk); x = 4'b0111; y = 4'b1000;
    @(negedge clk); check("R5", int'(z), 0, "max < min");
    @(posedge clk); x = 4'b1010; y = 4'b1010;
    @(negedge clk); check("R5", int'(z), 0, "equal operands");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule